// File: doc/BRIEF.md
# Odd-Multiple Table Constant Multiplier

This block multiplies a 5-bit unsigned operand by a constant coefficient that is fixed at elaboration time. It does not hold all 32 products. A nine-word table keeps the value zero and the eight odd multiples of the coefficient (1A, 3A, ..., 15A). Any other product of the low four operand bits is one of those odd words shifted left. The top operand bit then adds 16A in a final adder.

Each cycle a caller presents an operand with a valid strobe. One clock edge later the block returns the product with a matching valid flag. When no new operand arrives, the product output keeps its last value. The block suits filter taps and other datapaths where the coefficient is known at build time.

Top module: `odd_lut_mul`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_prod` is 0 until the first accepted operand.
- R2: For every operand value 0..31 accepted with `in_valid` high, `out_prod` equals operand times `COEF` on the clock edge after acceptance.
- R3: `out_valid` on each clock edge equals the `in_valid` sampled on the previous edge.
- R4: On an edge where `in_valid` is low, the input operand has no effect and `out_prod` keeps its previous value.
- R5: The shift amount is 2 bits: s1 = NOT(x0 OR x1) and s0 = NOT(x0 OR NOT(x1 OR NOT x2)). For nonzero low bits this equals their trailing-zero count. Even operands 2, 4, 6, 8, 10, 12 and 14 therefore give an odd multiple shifted by 1, 2, 1, 3, 1, 2 and 1.
- R6: When the low four operand bits are all zero, the table slot holding zero is used. Operand 0 gives 0 and operand 16 gives exactly 16 times `COEF`.
- R7: When operand bit 4 is 1, the product is the low-bit product plus 16 times `COEF`, so it is never below 16 times `COEF`.
- R8: The product is `COEF_W`+5 bits wide. With the largest coefficient (all ones), operand 31 returns the full product with no bit lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_x | input | 5 | Unsigned operand |
| out_valid | output | 1 | Product valid, one edge after `in_valid` |
| out_prod | output | COEF_W+5 | Product operand times `COEF` |

## Verification
A full sweep of all 32 operands compares every product against a reference multiply. This catches any wrong table word, shift code or bias. Even operands with 1, 2 and 3 trailing zeros test each shift amount. Operands 0 and 16 test the zero slot with and without the bias. Random operands mixed with idle cycles test that the output holds and that valid stays aligned with its data. A second instance with the all-ones coefficient tests the top product bit at operand 31.

// File: rtl/oml_pkg.sv
package oml_pkg;
    localparam int unsigned X_W      = 5;
    localparam int unsigned LOW_W    = X_W - 1;
    localparam int unsigned SHAMT_W  = 2;
    localparam int unsigned TBL_WORDS = 9;
    localparam int unsigned SLOT_W   = 4;

    typedef logic [SHAMT_W-1:0] shamt_t;
    typedef logic [LOW_W-1:0]   low_t;
    typedef logic [SLOT_W-1:0]  slot_t;
endpackage

// File: rtl/oml_addr_gen.sv
module oml_addr_gen
    import oml_pkg::*;
(
    input  low_t   low_bits,
    output shamt_t shamt,
    output slot_t  slot
);
    logic s0, s1;
    low_t odd_part;

    always_comb begin
        s1       = ~(low_bits[0] | low_bits[1]);
        s0       = ~(low_bits[0] | ~(low_bits[1] | ~low_bits[2]));
        shamt    = {s1, s0};
        odd_part = low_bits >> shamt;
        if (odd_part == '0) begin
            slot = '0;
        end else begin
            slot = slot_t'({1'b0, odd_part[LOW_W-1:1]}) + slot_t'(1);
        end
    end
endmodule

// File: rtl/oml_odd_table.sv
module oml_odd_table
    import oml_pkg::*;
#(
    parameter int unsigned COEF_W = 8,
    parameter logic [COEF_W-1:0] COEF = 8'd173
) (
    input  slot_t               slot,
    output logic [COEF_W+3:0]   entry
);
    localparam int unsigned ENTRY_W = COEF_W + 4;

    logic [ENTRY_W-1:0] words [TBL_WORDS];

    for (genvar g = 0; g < int'(TBL_WORDS); g++) begin : g_word
        if (g == 0) begin : g_zero
            assign words[g] = '0;
        end else begin : g_odd
            assign words[g] = ENTRY_W'(COEF) * ENTRY_W'(2 * g - 1);
        end
    end

    always_comb begin
        entry = '0;
        for (int i = 0; i < int'(TBL_WORDS); i++) begin
            if (slot == slot_t'(i)) entry = words[i];
        end
    end
endmodule

// File: rtl/oml_shift_add.sv
module oml_shift_add
    import oml_pkg::*;
#(
    parameter int unsigned COEF_W = 8,
    parameter logic [COEF_W-1:0] COEF = 8'd173
) (
    input  logic [COEF_W+3:0] entry,
    input  shamt_t            shamt,
    input  logic              msb,
    output logic [COEF_W+4:0] prod
);
    localparam int unsigned PROD_W = COEF_W + 5;

    logic [PROD_W-1:0] shifted;
    logic [PROD_W-1:0] bias;

    always_comb begin
        shifted = PROD_W'(entry) << shamt;
        bias    = msb ? (PROD_W'(COEF) << LOW_W) : '0;
        prod    = shifted + bias;
    end
endmodule

// File: rtl/odd_lut_mul.sv
module odd_lut_mul
    import oml_pkg::*;
#(
    parameter int unsigned COEF_W = 8,
    parameter logic [COEF_W-1:0] COEF = 8'd173
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [4:0]        in_x,
    output logic              out_valid,
    output logic [COEF_W+4:0] out_prod
);
    localparam int unsigned PROD_W  = COEF_W + 5;
    localparam int unsigned ENTRY_W = COEF_W + 4;

    typedef struct packed {
        logic              vld;
        logic [PROD_W-1:0] prod;
    } stage_t;

    stage_t st_d, st_q;

    shamt_t             shamt;
    slot_t              slot;
    logic [ENTRY_W-1:0] entry;
    logic [PROD_W-1:0]  prod_c;

    oml_addr_gen u_addr (
        .low_bits (in_x[LOW_W-1:0]),
        .shamt    (shamt),
        .slot     (slot)
    );

    oml_odd_table #(.COEF_W(COEF_W), .COEF(COEF)) u_tbl (
        .slot  (slot),
        .entry (entry)
    );

    oml_shift_add #(.COEF_W(COEF_W), .COEF(COEF)) u_sa (
        .entry (entry),
        .shamt (shamt),
        .msb   (in_x[X_W-1]),
        .prod  (prod_c)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) st_d.prod = prod_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_prod  = st_q.prod;
endmodule

// File: rtl/oml_chk.sv
module oml_chk #(
    parameter int unsigned COEF_W = 8,
    parameter logic [COEF_W-1:0] COEF = 8'd173
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [4:0]        in_x,
    input logic              out_valid,
    input logic [COEF_W+4:0] out_prod
);
    localparam int unsigned PROD_W = COEF_W + 5;
    localparam logic [PROD_W-1:0] BIAS = PROD_W'(COEF) << 4;

    logic started_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) started_q <= 1'b0;
        else        started_q <= 1'b1;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && out_prod == '0));

    // R3
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> out_valid == $past(in_valid));

    // R4
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && !$past(in_valid)) |-> $stable(out_prod));

    // R6
    zero_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $past(in_valid) && $past(in_x) == 5'd0) |-> out_prod == '0);

    // R7
    bias_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $past(in_valid) && $past(in_x[4])) |-> out_prod >= BIAS);

    // R2
    prod_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $past(in_valid)) |-> out_prod <= PROD_W'(COEF) * PROD_W'(31));
endmodule

bind odd_lut_mul oml_chk #(.COEF_W(COEF_W), .COEF(COEF)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_x      (in_x),
    .out_valid (out_valid),
    .out_prod  (out_prod)
);

// File: tb/odd_lut_mul_tb.sv
module odd_lut_mul_tb;
    localparam int unsigned COEF_W = 8;
    localparam logic [COEF_W-1:0] COEF_A = 8'd173;
    localparam logic [COEF_W-1:0] COEF_M = 8'd255;
    localparam int unsigned PROD_W = COEF_W + 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [4:0] in_x = '0;
    logic out_valid, out_valid_m;
    logic [PROD_W-1:0] out_prod, out_prod_m;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [PROD_W-1:0] exp_a = '0;
    logic [PROD_W-1:0] exp_m = '0;

    always #5 clk = ~clk;

    odd_lut_mul #(.COEF_W(COEF_W), .COEF(COEF_A)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
        .out_valid(out_valid), .out_prod(out_prod)
    );

    odd_lut_mul #(.COEF_W(COEF_W), .COEF(COEF_M)) u_dut_max (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
        .out_valid(out_valid_m), .out_prod(out_prod_m)
    );

    function automatic logic [PROD_W-1:0] ref_mul(input logic [4:0] x, input logic [COEF_W-1:0] c);
        return PROD_W'(x) * PROD_W'(c);
    endfunction

    task automatic check(input string req, input logic [PROD_W-1:0] act, input logic [PROD_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive at negedge, check at next negedge
    task automatic step(input logic [4:0] x, input logic v, input string req);
        in_x = x;
        in_valid = v;
        @(posedge clk);
        @(negedge clk);
        if (v) begin
            exp_a = ref_mul(x, COEF_A);
            exp_m = ref_mul(x, COEF_M);
        end
        check("R3 valid", PROD_W'(out_valid), PROD_W'(v));
        check(req, out_prod, exp_a);
        check({req, " max"}, out_prod_m, exp_m);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [4:0] rx;
        logic rv;
        void'($urandom(32'd20211));
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 valid", PROD_W'(out_valid), '0);
        check("R1 prod", out_prod, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", out_prod, '0);
        check("R1 valid after release", PROD_W'(out_valid), '0);

        // R6 zero slot with and without bias
        step(5'd0, 1'b1, "R6 x=0");
        step(5'd16, 1'b1, "R6 x=16");
        // R5 each shift amount
        step(5'd2, 1'b1, "R5 x=2");
        step(5'd4, 1'b1, "R5 x=4");
        step(5'd8, 1'b1, "R5 x=8");
        step(5'd12, 1'b1, "R5 x=12");
        step(5'd14, 1'b1, "R5 x=14");
        // R7 bias with shifted words
        step(5'd24, 1'b1, "R7 x=24");
        step(5'd17, 1'b1, "R7 x=17");
        // R8 top of range
        step(5'd31, 1'b1, "R8 x=31");
        // R4 idle with changing input
        step(5'd5, 1'b0, "R4 idle");
        step(5'd9, 1'b0, "R4 idle");

        // R2 exhaustive sweep
        for (int i = 0; i < 32; i++) begin
            step(5'(i), 1'b1, "R2 sweep");
        end

        // R2/R4 random mix
        for (int i = 0; i < 400; i++) begin
            rx = 5'($urandom_range(0, 31));
            rv = ($urandom_range(0, 3) != 0);
            step(rx, rv, rv ? "R2 random" : "R4 random idle");
        end

        in_valid = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule